// File: doc/BRIEF.md
# Adaptive Transmit FIFO Trigger Level

This block holds the transmit FIFO threshold: the amount of data, counted in 64-byte units, that must be buffered before a transmission is allowed to start. A raise request, typically issued after an underrun, pushes the threshold up. The push is half the remaining distance to the ceiling, so the first raises are large and later ones are small. A lower request steps the threshold down by a single unit, but never below the floor.

Each adjustment takes two cycles. In the first cycle the global interrupt gate output is held low. In the second cycle the threshold is committed, a one-cycle done pulse is raised, and the gate returns to the value it had before the request. A status flag reports whether the last adjustment was refused because it hit a bound. When the block is idle, the gate output follows the requested global interrupt enable one cycle later.

Top module: `tx_trig_tuner`

## Requirements
- R1: After reset the level is 1 (64 bytes), the done pulse and the fail flag are 0, and the interrupt gate is 0.
- R2: An accepted raise request sets the level to level + floor((63 - level) / 2). Starting from 1, successive raises give 32, 47, 55, 59, 61 and 62.
- R3: An accepted lower request sets the level to level - 1 when the level is above 1.
- R4: A lower request at level 1 is refused. The fail flag is set to 1 and the level stays at 1.
- R5: A raise request whose computed step is 0 (level 62 or 63) is refused. The fail flag is set to 1 and the level is unchanged.
- R6: A request sampled while idle drives the interrupt gate to 0 for the next cycle. After the following edge the gate again shows the value it had before the request, whatever the enable input did in between.
- R7: A request sampled at edge E0 updates the level at edge E0+1. `done` is 1 for exactly the one cycle after E0+1.
- R8: When raise and lower are requested in the same cycle, the raise is performed.
- R9: Requests sampled while an update is in progress are ignored. They change neither the level nor the number of done pulses.
- R10: The fail flag keeps its value from one done pulse until the next. A successful adjustment clears it.
- R11: While idle, the interrupt gate equals the enable input as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_req | input | 1 | Request to raise the threshold (one-cycle pulse) |
| dec_req | input | 1 | Request to lower the threshold (one-cycle pulse) |
| irq_en_in | input | 1 | Requested global interrupt enable |
| irq_gate | output | 1 | Global interrupt gate, forced low while an update is in progress |
| level | output | 6 | Current threshold in 64-byte units |
| done | output | 1 | One-cycle pulse when an adjustment finishes |
| fail | output | 1 | Set when the last adjustment was refused at a bound |

## Verification
The assertions check a set of properties on every cycle:
- the level never leaves the range 1 to 63;
- the level changes only in a done cycle;
- a refused adjustment leaves the level untouched;
- a lower request moves the level by exactly one;
- the gate is low in the cycle after an accepted request.

Other behaviours can only be shown by the bench scenarios:
- the exact sequence of halving raises from reset;
- refusal at both bounds;
- raise priority when both requests arrive together;
- requests ignored while busy;
- the gate returning to its pre-request value even though the enable input changed during the update.

// File: rtl/tx_trig_pkg.sv
// Package: shared constants and types for the transmit trigger level tuner.
// Assumes: the level is counted in 64-byte units.
package tx_trig_pkg;
    localparam int TRIG_LVL_W   = 6;
    localparam int TRIG_LVL_MIN = 1;
    localparam int TRIG_LVL_MAX = 63;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_GATE = 1'b1
    } trig_state_t;
endpackage

// File: rtl/tx_trig_calc.sv
// Module: tx_trig_calc
// Works out the candidate next level and whether the adjustment must be
// refused.
// - Raise: adds half the gap to the maximum (integer division).
// - Lower: subtracts one.
// Assumes: the level input already lies within [LVL_MIN, LVL_MAX].
module tx_trig_calc #(
    parameter int LVL_W   = 6,
    parameter int LVL_MIN = 1,
    parameter int LVL_MAX = 63
) (
    input  logic [LVL_W-1:0] cur_level,
    input  logic             dir_up,
    output logic [LVL_W-1:0] nxt_level,
    output logic             refuse
);
    localparam int EXT_W = LVL_W + 1;
    localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'(LVL_MAX);
    localparam logic [EXT_W-1:0] MIN_EXT = EXT_W'(LVL_MIN);

    logic [EXT_W-1:0] cur_ext;
    logic [EXT_W-1:0] up_step;

    // Purpose: compute the candidate level and the refusal for the requested direction.
    always_comb begin
        cur_ext = {1'b0, cur_level};
        up_step = (MAX_EXT - cur_ext) >> 1;
        if (dir_up) begin
            refuse    = (up_step == '0);
            nxt_level = LVL_W'(cur_ext + up_step);
        end else begin
            refuse    = (cur_ext <= MIN_EXT);
            nxt_level = LVL_W'(cur_ext - 1'b1);
        end
    end
endmodule

// File: rtl/tx_trig_seq.sv
// Module: tx_trig_seq
// Sequencer for the two-cycle update.
// - Accepts a request only while idle; a raise wins over a lower.
// - Holds the interrupt gate low for one cycle, then restores the saved value.
// - Raises the commit strobe and a registered done pulse.
// Assumes: requests are one-cycle pulses; requests that arrive while busy are dropped.
module tx_trig_seq
    import tx_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_req,
    input  logic dec_req,
    input  logic irq_en_in,
    output logic commit,
    output logic dir_up,
    output logic irq_gate,
    output logic done
);
    trig_state_t state;
    logic        gate_saved;
    logic        accept;

    // Purpose: detect a request that can start an update.
    always_comb begin
        accept = (state == ST_IDLE) && (inc_req || dec_req);
        commit = (state == ST_GATE);
    end

    // Purpose: step the state machine and register the gate, direction and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gate_saved <= 1'b0;
            dir_up     <= 1'b0;
            irq_gate   <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state      <= ST_GATE;
                        gate_saved <= irq_gate;
                        dir_up     <= inc_req;
                        irq_gate   <= 1'b0;
                    end else begin
                        irq_gate   <= irq_en_in;
                    end
                end
                default: begin
                    state    <= ST_IDLE;
                    irq_gate <= gate_saved;
                    done     <= 1'b1;
                end
            endcase
        end
    end

    // R6: the gate is low for the whole cycle after a request is accepted.
    a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !irq_gate);
    // R8: with both requests present, the raise direction is latched.
    a_r8_inc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && inc_req) |=> dir_up);
    // R9: no request is accepted while an update is in flight.
    a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == ST_IDLE));
    // R7: done follows the commit cycle and lasts a single cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/tx_trig_tuner.sv
// Module: tx_trig_tuner (top)
// Holds the transmit FIFO trigger level and the fail flag.
// Updates both on the commit cycle of the sequencer.
// Assumes: the level is in 64-byte units and resets to the floor value.
module tx_trig_tuner
    import tx_trig_pkg::*;
#(
    parameter int LVL_W   = TRIG_LVL_W,
    parameter int LVL_MIN = TRIG_LVL_MIN,
    parameter int LVL_MAX = TRIG_LVL_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_req,
    input  logic             dec_req,
    input  logic             irq_en_in,
    output logic             irq_gate,
    output logic [LVL_W-1:0] level,
    output logic             done,
    output logic             fail
);
    localparam logic [LVL_W-1:0] RESET_LVL = LVL_W'(LVL_MIN);

    logic             commit;
    logic             dir_up;
    logic [LVL_W-1:0] nxt_level;
    logic             refuse;

    tx_trig_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_req   (inc_req),
        .dec_req   (dec_req),
        .irq_en_in (irq_en_in),
        .commit    (commit),
        .dir_up    (dir_up),
        .irq_gate  (irq_gate),
        .done      (done)
    );

    tx_trig_calc #(
        .LVL_W   (LVL_W),
        .LVL_MIN (LVL_MIN),
        .LVL_MAX (LVL_MAX)
    ) u_calc (
        .cur_level (level),
        .dir_up    (dir_up),
        .nxt_level (nxt_level),
        .refuse    (refuse)
    );

    // Purpose: commit the level only on success; record the refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= RESET_LVL;
            fail  <= 1'b0;
        end else if (commit) begin
            fail <= refuse;
            if (!refuse) begin
                level <= nxt_level;
            end
        end
    end

    // R2/R4: the level stays inside its legal range.
    a_r4_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= RESET_LVL) && (int'(level) <= LVL_MAX));
    // R7: the level moves only in a done cycle.
    a_r7_level_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(level));
    // R5: a refused adjustment leaves the level untouched.
    a_r5_refused_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> $stable(level));
    // R3: a successful lower moves the level by exactly one.
    a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && !dir_up) |-> (level == $past(level) - 1'b1));
    // R10: the fail flag changes only when an adjustment finishes.
    a_r10_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(fail));
endmodule

// File: tb/tx_trig_tuner_tb.sv
// Directed bench for tx_trig_tuner: one task per scenario, each checking its own results.
module tx_trig_tuner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc_req = 1'b0;
    logic       dec_req = 1'b0;
    logic       irq_en_in = 1'b0;
    logic       irq_gate;
    logic [5:0] level;
    logic       done;
    logic       fail;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    tx_trig_tuner u_dut (
        .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .dec_req(dec_req),
        .irq_en_in(irq_en_in), .irq_gate(irq_gate), .level(level),
        .done(done), .fail(fail)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request and follow it through both update cycles.
    task automatic run_req(input logic up, input logic down, input int exp_lvl,
                           input int exp_fail, input string tag);
        int gate_before;
        @(negedge clk);
        gate_before = irq_gate;
        inc_req = up;
        dec_req = down;
        @(negedge clk);
        inc_req = 1'b0;
        dec_req = 1'b0;
        check({tag, " R6 gate low"}, irq_gate, 0);
        check({tag, " R7 no done yet"}, done, 0);
        @(negedge clk);
        check({tag, " R7 done"}, done, 1);
        check({tag, " level"}, level, exp_lvl);
        check({tag, " fail"}, fail, exp_fail);
        check({tag, " R6 gate restored"}, irq_gate, gate_before);
        @(negedge clk);
        check({tag, " R7 done single"}, done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        irq_en_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 level", level, 1);
        check("R1 done", done, 0);
        check("R1 fail", fail, 0);
        check("R1 gate", irq_gate, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 gate follows enable", irq_gate, 1);
    endtask

    task automatic t_inc_chain();
        int exp_seq[6] = '{32, 47, 55, 59, 61, 62};
        foreach (exp_seq[i]) run_req(1'b1, 1'b0, exp_seq[i], 0, "R2 raise");
    endtask

    task automatic t_inc_ceiling();
        run_req(1'b1, 1'b0, 62, 1, "R5 raise refused at 62");
        check("R10 fail held", fail, 1);
    endtask

    task automatic t_dec();
        run_req(1'b0, 1'b1, 61, 0, "R3 lower");
        check("R10 fail cleared", fail, 0);
    endtask

    task automatic t_both();
        run_req(1'b1, 1'b1, 62, 0, "R8 both gives raise");
    endtask

    task automatic t_dec_floor();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_req(1'b0, 1'b1, 1, 1, "R4 lower refused at 1");
    endtask

    // A raise arriving during the gate cycle must be dropped.
    task automatic t_busy_ignore();
        @(negedge clk);
        dec_req = 1'b1;
        @(negedge clk);
        dec_req = 1'b0;
        inc_req = 1'b1;
        @(negedge clk);
        inc_req = 1'b0;
        check("R9 first update done", done, 1);
        check("R9 level after lower", level, 60);
        repeat (3) begin
            @(negedge clk);
            check("R9 no extra done", done, 0);
        end
        check("R9 level unchanged", level, 60);
    endtask

    // The enable input drops mid-update; the gate restores its prior value first.
    task automatic t_gate_restore();
        irq_en_in = 1'b1;
        @(negedge clk);
        inc_req = 1'b1;
        @(negedge clk);
        inc_req = 1'b0;
        irq_en_in = 1'b0;
        check("R6 gate low during update", irq_gate, 0);
        @(negedge clk);
        check("R6 gate restored to prior", irq_gate, 1);
        check("R2 raise from 60", level, 61);
        @(negedge clk);
        check("R11 gate follows enable low", irq_gate, 0);
        irq_en_in = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_inc_chain();
        t_inc_ceiling();
        t_dec();
        t_both();
        run_req(1'b0, 1'b1, 61, 0, "R3 lower again");
        t_busy_ignore();
        t_gate_restore();
        t_dec_floor();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule